// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This execute-stage unit carries out the six control/status register instructions of a RISC-V style pipeline against a small machine-mode register file. Each request carries a `funct3` operation code, the source register index and its value, the destination register index and a 12-bit CSR address. The source register index also serves as the 5-bit immediate in the immediate forms. The unit reads the old CSR value for writeback to `rd`. It forms the new value by write, set or clear, and decides whether a write happens at all. Registers with side effects depend on that decision.

The write rule differs between forms. Set and clear with a zero operand field (`x0` or immediate 0) leave the CSR untouched. Write forms always write, even when the operand is zero, so they clear the register. A write form whose destination is `x0` skips the read and its side effects. A write aimed at an address whose two top bits are `11` is refused and raises an illegal-instruction flag. All results are registered and appear one cycle after the request.

Top module: `csr_access_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls with no request, every output is 0.
- R2: A request sampled with `req_valid` high produces `rsp_valid` high on the next cycle with all other results. Without a request, `rsp_valid`, `csr_we`, `rd_we`, `csr_re` and `illegal` are 0 on the next cycle.
- R3: `funct3` 001/010/011 select register write/set/clear. 101/110/111 select the immediate forms. 000 and 100 are not CSR operations: they raise `illegal` with no read and no write.
- R4: Write forms store the operand. The operand is `rs1_val` in register forms. In immediate forms (`funct3[2]`=1) it is `rs1_idx` zero-extended to XLEN.
- R5: Set stores old OR operand. Clear stores old AND NOT operand.
- R6: Set and clear with `rs1_idx` = 0 perform no write (`csr_we`=0, stored value unchanged) but still read the CSR.
- R7: Write forms with `rs1_idx` = 0 still write. The immediate form stores 0, and the register form stores `rs1_val`.
- R8: When a read happens, `rd_data` is the CSR value before the instruction, and `rd_we` is 1 exactly when `rd_idx` is nonzero.
- R9: A write form with `rd_idx` = 0 performs no read: `csr_re`=0, `rd_we`=0, `rd_data`=0.
- R10: If a write would happen and `csr_addr[11:10]` is `11`, then `illegal`=1, no write, no read, and the stored value is unchanged. Set or clear with a zero operand to such an address is a legal read.
- R11: A request issued on the cycle right after a write to the same CSR reads the newly written value.
- R12: `csr_waddr` and `csr_wdata` report the address and value stored whenever `csr_we` is 1. The register file holds 2^IDX_W entries selected by the low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| funct3 | input | 3 | Operation code |
| rs1_idx | input | 5 | Source register index, or 5-bit immediate |
| rs1_val | input | XLEN | Source register value |
| rd_idx | input | 5 | Destination register index |
| csr_addr | input | ADDR_W | CSR address |
| rsp_valid | output | 1 | Results valid |
| rd_we | output | 1 | Write old value back to rd |
| rd_data | output | XLEN | Old CSR value (0 if not read) |
| csr_re | output | 1 | CSR was read (read side effects) |
| csr_we | output | 1 | CSR was written |
| csr_waddr | output | ADDR_W | Address written |
| csr_wdata | output | XLEN | Value written |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
Every result is due one rising edge after the request edge. The old value, the write decision, the written value and the illegal flag all come out of the same output register. The write reaches the register file at that same edge, so a request on the next cycle already reads it. The bench drives each request on a falling edge and compares the outputs at the following falling edge, against a reference model that is updated only after that comparison. Back-to-back requests therefore exercise the read-after-write case with no idle cycles.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;
  // Low two bits of funct3 select the operation kind.
  typedef enum logic [1:0] {
    OPK_NONE  = 2'b00,
    OPK_WRITE = 2'b01,
    OPK_SET   = 2'b10,
    OPK_CLEAR = 2'b11
  } csr_opk_e;

  localparam logic [1:0] RO_PREFIX = 2'b11;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_unit_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] funct3,
  input  logic [4:0] rs1_idx,
  input  logic [4:0] rd_idx,
  input  logic [1:0] addr_top,
  output csr_opk_e   opk,
  output logic       use_imm,
  output logic       do_read,
  output logic       do_write,
  output logic       bad_op
);
  logic not_csr;
  logic wants_write;
  logic read_only;

  always_comb begin
    opk         = csr_opk_e'(funct3[1:0]);
    use_imm     = funct3[2];
    not_csr     = (opk == OPK_NONE);
    read_only   = (addr_top == RO_PREFIX);
    // write forms always write; set/clear only with a nonzero field
    wants_write = (opk == OPK_WRITE) || (rs1_idx != 5'd0);
    bad_op      = valid && (not_csr || (wants_write && read_only));
    do_write    = valid && !bad_op && wants_write;
    do_read     = valid && !bad_op && !((opk == OPK_WRITE) && (rd_idx == 5'd0));
  end
endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
  import csr_unit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_opk_e          opk,
  input  logic [XLEN-1:0]   old_val,
  input  logic [XLEN-1:0]   operand,
  output logic [XLEN-1:0]   new_val
);
  always_comb begin
    unique case (opk)
      OPK_WRITE: new_val = operand;
      OPK_SET:   new_val = old_val | operand;
      OPK_CLEAR: new_val = old_val & ~operand;
      default:   new_val = old_val;
    endcase
  end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [XLEN-1:0]   rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [XLEN-1:0] mem [DEPTH];

  // synchronous write, asynchronous read: distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_unit_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        funct3,
  input  logic [4:0]        rs1_idx,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [4:0]        rd_idx,
  input  logic [ADDR_W-1:0] csr_addr,
  output logic              rsp_valid,
  output logic              rd_we,
  output logic [XLEN-1:0]   rd_data,
  output logic              csr_re,
  output logic              csr_we,
  output logic [ADDR_W-1:0] csr_waddr,
  output logic [XLEN-1:0]   csr_wdata,
  output logic              illegal
);
  localparam int IMM_PAD = XLEN - 5;

  csr_opk_e        opk;
  logic            use_imm, do_read, do_write, bad_op;
  logic [XLEN-1:0] old_val, operand, new_val;

  csr_op_decode u_dec (
    .valid    (req_valid),
    .funct3   (funct3),
    .rs1_idx  (rs1_idx),
    .rd_idx   (rd_idx),
    .addr_top (csr_addr[ADDR_W-1 -: 2]),
    .opk      (opk),
    .use_imm  (use_imm),
    .do_read  (do_read),
    .do_write (do_write),
    .bad_op   (bad_op)
  );

  assign operand = use_imm ? {{IMM_PAD{1'b0}}, rs1_idx} : rs1_val;

  csr_regfile #(.XLEN(XLEN), .IDX_W(IDX_W)) u_rf (
    .clk   (clk),
    .we    (do_write),
    .waddr (csr_addr[IDX_W-1:0]),
    .wdata (new_val),
    .raddr (csr_addr[IDX_W-1:0]),
    .rdata (old_val)
  );

  csr_rmw_alu #(.XLEN(XLEN)) u_alu (
    .opk     (opk),
    .old_val (old_val),
    .operand (operand),
    .new_val (new_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rd_we     <= 1'b0;
      rd_data   <= '0;
      csr_re    <= 1'b0;
      csr_we    <= 1'b0;
      csr_waddr <= '0;
      csr_wdata <= '0;
      illegal   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rd_we     <= do_read && (rd_idx != 5'd0);
      rd_data   <= do_read ? old_val : '0;
      csr_re    <= do_read;
      csr_we    <= do_write;
      csr_waddr <= do_write ? csr_addr : '0;
      csr_wdata <= do_write ? new_val : '0;
      illegal   <= bad_op;
    end
  end

  // set/clear with zero field never writes
  assert_setclr_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && funct3[1] && rs1_idx == 5'd0) |=> !csr_we);

  // write forms to a writable address always write
  assert_write_always_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && funct3[1:0] == 2'b01 && csr_addr[ADDR_W-1 -: 2] != RO_PREFIX) |=> csr_we);

  // refused write leaves no write and no writeback
  assert_illegal_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!csr_we && !rd_we && !csr_re));

  // no request, no response
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !csr_we && !illegal));

  // writeback only after a read
  assert_wb_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
    !csr_re |-> (!rd_we && rd_data == '0));

  // write reported only inside a response
  assert_write_in_rsp_R12: assert property (@(posedge clk) disable iff (rst)
    csr_we |-> rsp_valid);
endmodule

// File: tb/sim_csr_access_unit.sv
module sim_csr_access_unit;
  localparam int XLEN = 32;
  localparam int ADDR_W = 12;
  localparam int IDX_W = 3;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] funct3 = '0;
  logic [4:0] rs1_idx = '0;
  logic [XLEN-1:0] rs1_val = '0;
  logic [4:0] rd_idx = '0;
  logic [ADDR_W-1:0] csr_addr = '0;
  logic rsp_valid, rd_we, csr_re, csr_we, illegal;
  logic [XLEN-1:0] rd_data, csr_wdata;
  logic [ADDR_W-1:0] csr_waddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [XLEN-1:0] model [DEPTH];

  always #5 clk = ~clk;

  csr_access_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .funct3(funct3),
    .rs1_idx(rs1_idx), .rs1_val(rs1_val), .rd_idx(rd_idx), .csr_addr(csr_addr),
    .rsp_valid(rsp_valid), .rd_we(rd_we), .rd_data(rd_data), .csr_re(csr_re),
    .csr_we(csr_we), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata), .illegal(illegal)
  );

  // packed view of outputs: valid,rd_we,re,we,ill,rd_data,waddr,wdata
  function automatic logic [5+2*XLEN+ADDR_W-1:0] outs();
    return {rsp_valid, rd_we, csr_re, csr_we, illegal, rd_data, csr_waddr, csr_wdata};
  endfunction

  task automatic check(string tag, logic [5+2*XLEN+ADDR_W-1:0] got, logic [5+2*XLEN+ADDR_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // reference model: expected outputs of one request, and model update
  logic [5+2*XLEN+ADDR_W-1:0] pend_exp;
  string pend_tag;
  logic pend_live = 1'b0;

  task automatic issue(input logic [2:0] f3, input logic [4:0] r1, input logic [XLEN-1:0] v,
                       input logic [4:0] rd, input logic [ADDR_W-1:0] a);
    logic [1:0] k;
    logic wants, bad, wr, rdx;
    logic [XLEN-1:0] opd, oldv, newv;
    @(negedge clk);
    if (pend_live) check(pend_tag, outs(), pend_exp);
    k = f3[1:0];
    opd = f3[2] ? {{(XLEN-5){1'b0}}, r1} : v;                  // R4
    wants = (k == 2'b01) || (r1 != 5'd0);                       // R6 R7
    bad = (k == 2'b00) || (wants && a[ADDR_W-1 -: 2] == 2'b11); // R3 R10
    wr = !bad && wants;
    rdx = !bad && !(k == 2'b01 && rd == 5'd0);                  // R9
    oldv = model[a[IDX_W-1:0]];
    case (k)
      2'b01: newv = opd;
      2'b10: newv = oldv | opd;                                 // R5
      2'b11: newv = oldv & ~opd;
      default: newv = oldv;
    endcase
    pend_exp = {1'b1, rdx && rd != 5'd0, rdx, wr, bad,
                rdx ? oldv : {XLEN{1'b0}}, wr ? a : {ADDR_W{1'b0}},
                wr ? newv : {XLEN{1'b0}}};                      // R8 R12
    if (bad) pend_tag = (k == 2'b00) ? "R3" : "R10";
    else if (k == 2'b01) pend_tag = (r1 == 0) ? "R7" : "R4";
    else pend_tag = (r1 == 0) ? "R6" : "R5";
    if (wr) model[a[IDX_W-1:0]] = newv;                         // R11
    pend_live = 1'b1;
    req_valid = 1'b1; funct3 = f3; rs1_idx = r1; rs1_val = v; rd_idx = rd; csr_addr = a;
  endtask

  task automatic idle();
    @(negedge clk);
    if (pend_live) check(pend_tag, outs(), pend_exp);
    pend_live = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check("R2", outs(), '0); // idle gives a quiet response
  endtask

  initial begin
    void'($urandom(32'd20240411));
    repeat (3) @(negedge clk);
    check("R1", outs(), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", outs(), '0);
    // fill every entry
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = '0;
      issue(3'b001, 5'd1, 32'hA5A5_0000 + i, 5'd0, 12'h300 + i);
    end
    idle();
    // directed corners
    issue(3'b010, 5'd0, 32'hFFFF_FFFF, 5'd3, 12'hC01); // R10 legal read of read-only
    issue(3'b011, 5'd4, 32'h0000_FFFF, 5'd3, 12'hC01); // R10 refused
    issue(3'b010, 5'd0, 32'h0, 5'd2, 12'h301);         // R6 read only, reg form
    issue(3'b110, 5'd0, 32'h0, 5'd2, 12'h302);         // R6 imm form
    issue(3'b101, 5'd0, 32'h1234, 5'd5, 12'h303);      // R7 imm clear
    issue(3'b001, 5'd0, 32'h0, 5'd5, 12'h304);         // R7 reg form x0 value
    issue(3'b010, 5'd0, 32'h0, 5'd6, 12'h304);         // R11 back-to-back read
    issue(3'b001, 5'd7, 32'hDEAD_BEEF, 5'd0, 12'h305); // R9 no read
    issue(3'b000, 5'd7, 32'h1, 5'd1, 12'h305);         // R3 invalid
    issue(3'b100, 5'd7, 32'h1, 5'd1, 12'h305);         // R3 invalid
    issue(3'b111, 5'd31, 32'h0, 5'd1, 12'h300);        // R5 clear imm
    issue(3'b110, 5'd17, 32'h0, 5'd1, 12'h300);        // R5 set imm
    idle();
    // constrained random
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] f3;
      logic [4:0] r1, rd;
      logic [ADDR_W-1:0] a;
      f3 = 3'($urandom_range(0, 7));
      r1 = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      rd = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      a = 12'($urandom);
      if ($urandom_range(0, 2) != 0) a[ADDR_W-1 -: 2] = 2'b00;
      if ($urandom_range(0, 9) == 0) idle();
      else issue(f3, r1, $urandom, rd, a);
    end
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL R2 watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule